// File: doc/BRIEF.md
# Scratchpad Copy Engine

This block holds a 64-byte scratchpad that any bus master may fill and read back. Nothing guards it. Once the master has checked the contents, it can move a region of the scratchpad into one of four secure subkey areas. The region is either a single 8-byte block or all 64 bytes. The move goes ahead only when the master supplies the destination subkey's 8-byte password and that password matches the stored one. After a completed move, the engine clears the source bytes in the scratchpad.

The engine takes its commands one byte at a time on a strobed input. Every command opens with a three-byte header:

- an operation code;
- an address byte, whose low six bits give the start address and whose top two bits pick the subkey;
- the bitwise inverse of the address byte.

The opcodes are 96h (fill), 69h (read back) and 3Ch (copy). For a fill, data bytes follow the header. For a read back, the master pulses a request line once per byte. For a copy, a selector byte follows the header, then the eight password bytes. The engine compares each password byte against the stored password supplied by subkey storage on `key_pw`. During the copy it drives a write port into subkey storage, one byte per clock.

A one-cycle `bus_rst` pulse ends any command. After it, the engine waits for a new header.

The state machine has these states:

| State | Role |
|-------|------|
| ST_CMD | waits for an opcode |
| ST_ADDR | waits for the address byte |
| ST_INV | waits for the inverse byte |
| ST_WRITE | fills the scratchpad |
| ST_READ | reads the scratchpad back |
| ST_SEL | waits for the selector byte |
| ST_PASS | collects the eight password bytes |
| ST_COPY | moves one byte per clock |
| ST_HOLD | ignores all input until `bus_rst` |

Its transitions are:

- ST_CMD→ST_ADDR on a known opcode.
- ST_CMD→ST_HOLD on any other opcode.
- ST_ADDR→ST_INV on any byte.
- ST_INV→ST_WRITE, ST_READ or ST_SEL, according to the opcode, when the inverse is correct.
- ST_INV→ST_HOLD when the inverse is wrong.
- ST_WRITE→ST_HOLD after address 63 has been written.
- ST_READ→ST_HOLD after address 63 has been read.
- ST_SEL→ST_PASS on a selector from 0 to 8.
- ST_SEL→ST_HOLD on any other selector.
- ST_PASS→ST_COPY when all eight password bytes match.
- ST_PASS→ST_HOLD on a password mismatch.
- ST_COPY→ST_HOLD after the last byte has moved.
- Any state→ST_CMD on `bus_rst`.

Top module: `scratch_copy_engine`

## Requirements
- R1: After `rst_n` is deasserted, `busy`, `kw_en` and `out_valid` are 0 and every scratchpad byte reads 00h.
- R2: Command 96h writes each `in_valid` byte at the header start address and then increments the address. Bytes that arrive after address 63 has been written are ignored.
- R3: Command 69h answers each `out_req` pulse on the following clock with `out_valid`=1 and the byte at the current address, starting at the header address. After address 63 has been read, `out_req` brings no further `out_valid`.
- R4: When the third header byte is not the bitwise inverse of the second, the command is dropped and the bytes that follow change nothing until `bus_rst`.
- R5: For command 3Ch, a selector value n from 0 to 7 copies scratchpad bytes 8n to 8n+7 to the same offsets of the subkey. The copy moves one byte per clock with `kw_addr` ascending and `busy`=1, starting on the clock after the eighth password byte.
- R6: Selector value 8 copies all 64 scratchpad bytes to offsets 0 to 63 of the subkey.
- R7: A selector value above 8 aborts the copy: no subkey write takes place and the scratchpad is unchanged.
- R8: Password bytes are taken least significant byte first, so byte i is compared with `key_pw[8i+7:8i]`. Any mismatch ends the command with no subkey write and with the scratchpad unchanged.
- R9: After a completed copy, the copied scratchpad bytes read 00h and all other bytes keep their values.
- R10: Bits 7:6 of the address byte select the subkey, and `key_sel` holds that value for the whole copy.
- R11: A `bus_rst` pulse during password entry or during the copy stops the command. Subkey bytes already written stay, no further subkey byte is written, the scratchpad is not cleared, and a new header is accepted.
- R12: An opcode other than 96h, 69h or 3Ch makes the engine ignore all input until `bus_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the scratchpad |
| bus_rst | input | 1 | Synchronous pulse that aborts the current command |
| in_valid | input | 1 | Strobe for `in_byte` |
| in_byte | input | 8 | Byte from the bus master |
| out_req | input | 1 | Request for the next read-back byte |
| out_valid | output | 1 | `out_byte` holds a read-back byte |
| out_byte | output | 8 | Read-back data |
| busy | output | 1 | Copy in progress |
| key_sel | output | 2 | Selected subkey |
| key_pw | input | 64 | Stored password of the subkey given by `key_sel` |
| kw_en | output | 1 | Subkey write strobe |
| kw_addr | output | 6 | Byte offset within the subkey |
| kw_data | output | 8 | Byte written to the subkey |

## Verification
The hardest situation to reach is a `bus_rst` that lands partway through a copy, after some subkey bytes are written and before the scratchpad is cleared. The bench gets there with a full 64-byte copy and a correct password. It then counts exactly three clocks after the final password byte and raises `bus_rst`. This leaves exactly three subkey bytes written. The bench then reads the whole scratchpad back through a fresh 69h command to show that nothing was cleared. The same read-back approach proves the clearing after a completed copy, and proves that aborted and rejected commands leave the scratchpad untouched.

// File: rtl/scp_pkg.sv
package scp_pkg;
    typedef enum logic [3:0] {
        ST_CMD, ST_ADDR, ST_INV, ST_WRITE, ST_READ,
        ST_SEL, ST_PASS, ST_COPY, ST_HOLD
    } scp_state_e;

    localparam logic [7:0] OP_WRITE = 8'h96;
    localparam logic [7:0] OP_READ  = 8'h69;
    localparam logic [7:0] OP_COPY  = 8'h3C;
endpackage

// File: rtl/scp_store.sv
module scp_store #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_lo,
    input  logic [AW-1:0] clr_hi,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [AW-1:0] IDX = AW'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (clr_en && IDX >= clr_lo && IDX <= clr_hi)
                mem[g] <= '0;
            else if (wr_en && wr_addr == IDX)
                mem[g] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/scp_pass_check.sv
module scp_pass_check #(
    parameter int PW_BYTES = 8,
    parameter int IW       = $clog2(PW_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  byte_en,
    input  logic [IW-1:0]         idx,
    input  logic [7:0]            byte_in,
    input  logic [8*PW_BYTES-1:0] ref_pw,
    output logic                  match_now
);
    logic       bad_q;
    logic [7:0] ref_byte;

    assign ref_byte  = ref_pw[8*idx +: 8];
    assign match_now = !bad_q && (byte_in == ref_byte);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bad_q <= 1'b0;
        else if (clear)
            bad_q <= 1'b0;
        else if (byte_en && byte_in != ref_byte)
            bad_q <= 1'b1;
    end
endmodule

// File: rtl/scratch_copy_engine.sv
module scratch_copy_engine
    import scp_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int BLK      = 8,
    parameter int PW_BYTES = 8,
    parameter int KEYS     = 4,
    localparam int AW      = $clog2(DEPTH),
    localparam int KW      = $clog2(KEYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_rst,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    input  logic                  out_req,
    output logic                  out_valid,
    output logic [7:0]            out_byte,
    output logic                  busy,
    output logic [KW-1:0]         key_sel,
    input  logic [8*PW_BYTES-1:0] key_pw,
    output logic                  kw_en,
    output logic [AW-1:0]         kw_addr,
    output logic [7:0]            kw_data
);
    localparam int NBLK = DEPTH / BLK;
    localparam int BW   = $clog2(BLK);
    localparam int IW   = $clog2(PW_BYTES);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    scp_state_e    state, nxt;
    logic [7:0]    op, abyte;
    logic [AW-1:0] addr, cnt, last, blk_lo;
    logic [IW-1:0] pidx;
    logic          pw_ok;
    logic [7:0]    rd_data;
    logic [AW-1:0] rd_addr;

    // storage and password compare
    assign rd_addr = (state == ST_COPY) ? cnt : addr;

    scp_store #(.DEPTH(DEPTH), .W(8), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (state == ST_WRITE && in_valid && !bus_rst),
        .wr_addr (addr),
        .wr_data (in_byte),
        .clr_en  (kw_en && cnt == last),
        .clr_lo  (blk_lo),
        .clr_hi  (last),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    scp_pass_check #(.PW_BYTES(PW_BYTES), .IW(IW)) u_pass (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == ST_SEL && in_valid),
        .byte_en   (state == ST_PASS && in_valid && !bus_rst),
        .idx       (pidx),
        .byte_in   (in_byte),
        .ref_pw    (key_pw),
        .match_now (pw_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (bus_rst) begin
            nxt = ST_CMD;
        end else begin
            unique case (state)
                ST_CMD:   if (in_valid)
                              nxt = (in_byte == OP_WRITE || in_byte == OP_READ ||
                                     in_byte == OP_COPY) ? ST_ADDR : ST_HOLD;
                ST_ADDR:  if (in_valid) nxt = ST_INV;
                ST_INV:   if (in_valid) begin
                              if (in_byte != ~abyte)  nxt = ST_HOLD;
                              else if (op == OP_WRITE) nxt = ST_WRITE;
                              else if (op == OP_READ)  nxt = ST_READ;
                              else                     nxt = ST_SEL;
                          end
                ST_WRITE: if (in_valid && addr == LAST_ADDR) nxt = ST_HOLD;
                ST_READ:  if (out_req && addr == LAST_ADDR) nxt = ST_HOLD;
                ST_SEL:   if (in_valid)
                              nxt = (in_byte <= 8'(NBLK)) ? ST_PASS : ST_HOLD;
                ST_PASS:  if (in_valid && pidx == IW'(PW_BYTES - 1))
                              nxt = pw_ok ? ST_COPY : ST_HOLD;
                ST_COPY:  if (cnt == last) nxt = ST_HOLD;
                ST_HOLD:  nxt = ST_HOLD;
                default:  nxt = ST_CMD;
            endcase
        end
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op        <= '0;
            abyte     <= '0;
            addr      <= '0;
            key_sel   <= '0;
            cnt       <= '0;
            last      <= '0;
            blk_lo    <= '0;
            pidx      <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (!bus_rst) begin
                unique case (state)
                    ST_CMD:   if (in_valid) op <= in_byte;
                    ST_ADDR:  if (in_valid) abyte <= in_byte;
                    ST_INV:   if (in_valid && in_byte == ~abyte) begin
                                  addr    <= abyte[AW-1:0];
                                  key_sel <= abyte[AW +: KW];
                              end
                    ST_WRITE: if (in_valid) addr <= addr + 1'b1;
                    ST_READ:  if (out_req) begin
                                  out_byte  <= rd_data;
                                  out_valid <= 1'b1;
                                  addr      <= addr + 1'b1;
                              end
                    ST_SEL:   if (in_valid) begin
                                  pidx <= '0;
                                  if (in_byte == 8'(NBLK)) begin
                                      cnt    <= '0;
                                      blk_lo <= '0;
                                      last   <= LAST_ADDR;
                                  end else begin
                                      cnt    <= {in_byte[AW-BW-1:0], {BW{1'b0}}};
                                      blk_lo <= {in_byte[AW-BW-1:0], {BW{1'b0}}};
                                      last   <= {in_byte[AW-BW-1:0], {BW{1'b1}}};
                                  end
                              end
                    ST_PASS:  if (in_valid) pidx <= pidx + 1'b1;
                    ST_COPY:  cnt <= cnt + 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    assign busy    = (state == ST_COPY);
    assign kw_en   = (state == ST_COPY) && !bus_rst;
    assign kw_addr = cnt;
    assign kw_data = rd_data;
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
    parameter int AW = 6,
    parameter int KW = 2,
    parameter int BW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rst,
    input logic          out_req,
    input logic          out_valid,
    input logic          busy,
    input logic [KW-1:0] key_sel,
    input logic          kw_en,
    input logic [AW-1:0] kw_addr
);
    always @(posedge clk)
        if (!rst_n) assert_reset_idle_R1: assert (!busy && !out_valid && !kw_en);

    assert_read_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(out_req));

    assert_copy_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kw_en && $past(kw_en) |-> kw_addr == $past(kw_addr) + AW'(1));

    assert_copy_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> kw_addr[BW-1:0] == '0);

    assert_keysel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(key_sel));

    assert_abort_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !busy && !out_valid);
endmodule

bind scratch_copy_engine scp_checker #(.AW(AW), .KW(KW), .BW($clog2(BLK))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst   (bus_rst),
    .out_req   (out_req),
    .out_valid (out_valid),
    .busy      (busy),
    .key_sel   (key_sel),
    .kw_en     (kw_en),
    .kw_addr   (kw_addr)
);

// File: tb/scratch_copy_engine_test.sv
`timescale 1ns/1ps
module scratch_copy_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        out_req = 1'b0;
    logic        out_valid, busy, kw_en;
    logic [7:0]  out_byte, kw_data;
    logic [1:0]  key_sel;
    logic [63:0] key_pw;
    logic [5:0]  kw_addr;

    logic [63:0] pw_tab [4];
    logic [7:0]  pad_m  [64];
    logic [7:0]  sk_m   [4][64];
    logic [7:0]  sk_mem [4][64];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign key_pw = pw_tab[key_sel];

    scratch_copy_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .in_valid(in_valid),
        .in_byte(in_byte), .out_req(out_req), .out_valid(out_valid),
        .out_byte(out_byte), .busy(busy), .key_sel(key_sel), .key_pw(key_pw),
        .kw_en(kw_en), .kw_addr(kw_addr), .kw_data(kw_data)
    );

    always @(posedge clk) if (kw_en) sk_mem[key_sel][kw_addr] <= kw_data;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_bus_rst();
        bus_rst = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic send(logic [7:0] b);
        in_valid = 1'b1; in_byte = b;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic hdr(logic [7:0] code, logic [7:0] a);
        send(code); send(a); send(~a);
    endtask

    task automatic read_one(output logic v, output logic [7:0] b);
        out_req = 1'b1;
        @(posedge clk); @(negedge clk);
        out_req = 1'b0;
        v = out_valid; b = out_byte;
    endtask

    task automatic read_all(string req);
        int bad = 0;
        logic v;
        logic [7:0] b;
        pulse_bus_rst();
        hdr(8'h69, 8'h00);
        for (int i = 0; i < 64; i++) begin
            read_one(v, b);
            if (!v || b !== pad_m[i]) begin
                bad++;
                $display("FAIL %s: byte %0d actual=%0h expected=%0h", req, i, b, pad_m[i]);
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic cmp_keys(string req);
        int bad = 0;
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 64; i++)
                if (sk_mem[k][i] !== sk_m[k][i]) bad++;
        chk(req, bad, 0);
    endtask

    task automatic fill(logic [7:0] seed);
        pulse_bus_rst();
        hdr(8'h96, 8'h00);
        for (int i = 0; i < 64; i++) begin
            pad_m[i] = seed + 8'(i * 7);
            send(pad_m[i]);
        end
    endtask

    task automatic copy_cmd(logic [1:0] sk, logic [7:0] sel, logic [63:0] pw);
        pulse_bus_rst();
        hdr(8'h3C, {sk, 6'd0});
        send(sel);
        for (int i = 0; i < 8; i++) send(pw[8*i +: 8]);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 kw_en", kw_en, 0);
        chk("R1 out_valid", out_valid, 0);
        read_all("R1 scratchpad zero");
    endtask

    task automatic t_write_read();
        logic v;
        logic [7:0] b;
        pulse_bus_rst();
        hdr(8'h96, 8'd60);
        for (int i = 0; i < 6; i++) send(8'hA0 + 8'(i));
        for (int i = 0; i < 4; i++) pad_m[60+i] = 8'hA0 + 8'(i);
        read_all("R2 write end stop");
        fill(8'h11);
        pulse_bus_rst();
        hdr(8'h69, 8'd10);
        for (int i = 0; i < 3; i++) begin
            read_one(v, b);
            chk("R3 read start valid", v, 1);
            chk("R3 read start data", b, pad_m[10+i]);
        end
        pulse_bus_rst();
        hdr(8'h69, 8'd62);
        read_one(v, b); chk("R3 read 62", {v, b}, {1'b1, pad_m[62]});
        read_one(v, b); chk("R3 read 63", {v, b}, {1'b1, pad_m[63]});
        read_one(v, b); chk("R3 past end", v, 0);
    endtask

    task automatic t_bad_header();
        pulse_bus_rst();
        send(8'h96); send(8'h05); send(8'h00);
        send(8'hEE); send(8'hEE);
        read_all("R4 bad inverse ignored");
        pulse_bus_rst();
        send(8'h55); send(8'h96); send(8'h00); send(8'hFF); send(8'h77);
        read_all("R12 unknown opcode ignored");
    endtask

    task automatic t_copy_block();
        copy_cmd(2'd1, 8'd2, pw_tab[1]);
        chk("R5 busy after password", busy, 1);
        chk("R10 key_sel", key_sel, 1);
        chk("R5 first kw_addr", kw_addr, 16);
        repeat (12) @(negedge clk);
        chk("R5 busy done", busy, 0);
        for (int i = 16; i < 24; i++) begin
            sk_m[1][i] = pad_m[i];
            pad_m[i]   = 8'h00;
        end
        cmp_keys("R5 block copy");
        read_all("R9 block erased");
    endtask

    task automatic t_copy_all();
        fill(8'h23);
        copy_cmd(2'd3, 8'd8, pw_tab[3]);
        chk("R10 key_sel full", key_sel, 3);
        repeat (70) @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            sk_m[3][i] = pad_m[i];
            pad_m[i]   = 8'h00;
        end
        cmp_keys("R6 full copy");
        read_all("R9 full erased");
    endtask

    task automatic t_rejects();
        fill(8'h37);
        copy_cmd(2'd0, 8'd9, pw_tab[0]);
        repeat (10) @(negedge clk);
        chk("R7 busy", busy, 0);
        cmp_keys("R7 no subkey write");
        read_all("R7 scratchpad kept");
        copy_cmd(2'd0, 8'd1, pw_tab[0] ^ (64'h1 << 56));
        repeat (10) @(negedge clk);
        chk("R8 busy", busy, 0);
        cmp_keys("R8 no subkey write");
        read_all("R8 scratchpad kept");
    endtask

    task automatic t_abort();
        pulse_bus_rst();
        hdr(8'h3C, 8'h00);
        send(8'd0);
        for (int i = 0; i < 3; i++) send(pw_tab[0][8*i +: 8]);
        pulse_bus_rst();
        repeat (10) @(negedge clk);
        cmp_keys("R11 abort in password");
        read_all("R11 password abort keeps pad");
        copy_cmd(2'd2, 8'd8, pw_tab[2]);
        repeat (3) @(negedge clk);
        pulse_bus_rst();
        chk("R11 busy after abort", busy, 0);
        repeat (70) @(negedge clk);
        for (int i = 0; i < 3; i++) sk_m[2][i] = pad_m[i];
        cmp_keys("R11 partial copy stays");
        read_all("R11 copy abort keeps pad");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        pw_tab[0] = 64'h0123_4567_89AB_CDEF;
        pw_tab[1] = 64'h1122_3344_5566_7788;
        pw_tab[2] = 64'hCAFE_F00D_DEAD_BEEF;
        pw_tab[3] = 64'h0F1E_2D3C_4B5A_6978;
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 64; i++) begin
                sk_m[k][i]   = 8'(k * 64 + i) ^ 8'hA5;
                sk_mem[k][i] = 8'(k * 64 + i) ^ 8'hA5;
            end
        for (int i = 0; i < 64; i++) pad_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_bad_header();
        t_copy_block();
        t_copy_all();
        t_rejects();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule